// File: doc/BRIEF.md
# Address-Space-Tagged Branch Target Buffer

This block is a direct-mapped table of branch targets for a fetch stage. A fetch PC, together with the identifier of the address space it belongs to, is looked up combinationally. The block returns a hit flag and the stored target. It also folds in the direction guess made elsewhere: a taken guess that finds no usable entry is turned into a not-taken prediction, because no target is known.

When a branch resolves, the back end presents its PC, address space, outcome and real target on the update port. Only branches that were actually taken allocate. The write overwrites the single entry that the PC maps to, since the table has no associativity. A synchronous reset invalidates every entry at once.

The PC is dropped by a fixed number of low bits (default 2). The next log2(entries) bits select the entry and the bits above those form the stored tag. The entry count, tag width, identifier width, PC width and shift are parameters.

Top module: `asid_btb`

## Requirements
- R1: For the cycle after reset, and until the first taken update, every lookup misses: `lk_hit` is 0 and `lk_target` is 0.
- R2: With S = `PC_SHIFT` and I = log2(`ENTRIES`), the entry index is PC[S+I-1:S] and the tag is the `TAG_W` bits directly above it. A lookup hits exactly when the indexed entry is valid and both its tag and its address space identifier equal those of the query.
- R3: An update with `upd_en`=1 and `upd_taken`=1 stores its tag, identifier and target at its index at the clock edge. From the next cycle, a lookup of that PC and identifier hits with `lk_target` equal to that target. On a miss `lk_target` is 0.
- R4: An update with `upd_taken`=0 leaves the table unchanged: earlier lookups return the same result afterwards.
- R5: A lookup whose index and tag match a valid entry but whose identifier differs misses.
- R6: A taken update to an index that already holds a different tag replaces that entry. The old PC then misses and the new PC hits.
- R7: When a lookup and a taken update address the same index in the same cycle, the lookup returns the contents from before the update.
- R8: `lk_taken` is 1 only when `lk_pred_taken` is 1 and the lookup hits. A taken guess that misses yields `lk_taken`=0.
- R9: PC bits below the shift and above the tag field do not affect the lookup.
- R10: Lookup outputs follow the lookup inputs within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; invalidates all entries, blocks updates |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_asid | input | ASID_W | Address space of the fetch |
| lk_pred_taken | input | 1 | Direction guess from the direction predictor |
| lk_hit | output | 1 | Valid entry with matching tag and identifier |
| lk_target | output | PC_W | Stored target on hit, zero on miss |
| lk_taken | output | 1 | Final taken prediction |
| upd_en | input | 1 | Resolved branch present |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_asid | input | ASID_W | Address space of the resolved branch |
| upd_taken | input | 1 | Actual outcome; only 1 allocates |
| upd_target | input | PC_W | Actual target |

## Verification
On every cycle the assertions check four things. Nothing hits right after reset. A taken write is visible to an identical lookup on the next cycle. A changed identifier or tag at the just-written index misses. Steady lookup inputs give steady results when no taken write occurred. Several properties need the bench's scenarios against a reference table: the old-data return when a read and a write collide in one cycle, the gating of the final direction by the hit flag, indifference to the ignored PC bits, and the combinational response within a cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Outcome of comparing one stored entry with a query
  typedef enum logic [1:0] {
    LK_MISS_EMPTY = 2'd0,
    LK_MISS_TAG   = 2'd1,
    LK_MISS_SPACE = 2'd2,
    LK_HIT        = 2'd3
  } lk_result_e;
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int IDX_W = 12,
  parameter int TAG_W = 16
) (
  input  logic [IDX_W+TAG_W-1:0] pc_field,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       tag
);
  // pc_field already has the shifted-out low bits removed
  assign idx = pc_field[IDX_W-1:0];
  assign tag = pc_field[IDX_W +: TAG_W];
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ENTRIES = 4096,
  parameter int TAG_W   = 16,
  parameter int ASID_W  = 8,
  parameter int TGT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WORD_W = TAG_W + ASID_W + TGT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [TGT_W-1:0]  wr_tgt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ASID_W-1:0] rd_asid,
  output logic [TGT_W-1:0]  rd_tgt
);
  // Payload: plain array without reset, written once per cycle
  logic [WORD_W-1:0] store_q [ENTRIES];
  // Valid bits kept apart so reset can clear them in one cycle
  logic [ENTRIES-1:0] valid_q;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= {wr_tag, wr_asid, wr_tgt};
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // Asynchronous read: returns pre-write contents during a same-index write
  assign rd_word  = store_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = rd_word[ASID_W+TGT_W +: TAG_W];
  assign rd_asid  = rd_word[TGT_W +: ASID_W];
  assign rd_tgt   = rd_word[TGT_W-1:0];
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int TAG_W  = 16,
  parameter int ASID_W = 8
) (
  input  logic                   ent_valid,
  input  logic [TAG_W-1:0]       ent_tag,
  input  logic [ASID_W-1:0]      ent_asid,
  input  logic [TAG_W-1:0]       q_tag,
  input  logic [ASID_W-1:0]      q_asid,
  output btb_pkg::lk_result_e    result
);
  always_comb begin
    if (!ent_valid)             result = btb_pkg::LK_MISS_EMPTY;
    else if (ent_tag != q_tag)  result = btb_pkg::LK_MISS_TAG;
    else if (ent_asid != q_asid) result = btb_pkg::LK_MISS_SPACE;
    else                        result = btb_pkg::LK_HIT;
  end
endmodule

// File: rtl/asid_btb.sv
module asid_btb #(
  parameter int ENTRIES  = 4096,
  parameter int TAG_W    = 16,
  parameter int ASID_W   = 8,
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int FIELD_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_pred_taken,
  output logic              lk_hit,
  output logic [PC_W-1:0]   lk_target,
  output logic              lk_taken,
  input  logic              upd_en,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [ASID_W-1:0] upd_asid,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_target
);
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [ASID_W-1:0] ent_asid;
  logic [PC_W-1:0]   ent_tgt;
  logic              alloc;
  btb_pkg::lk_result_e lk_res;

  btb_pc_split #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_lk (
    .pc_field(lk_pc[PC_SHIFT +: FIELD_W]), .idx(lk_idx), .tag(lk_tag));
  btb_pc_split #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_up (
    .pc_field(upd_pc[PC_SHIFT +: FIELD_W]), .idx(up_idx), .tag(up_tag));

  // Only resolved-taken branches allocate; reset blocks writes
  assign alloc = upd_en && upd_taken && !rst;

  btb_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ASID_W(ASID_W), .TGT_W(PC_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(alloc), .wr_idx(up_idx), .wr_tag(up_tag), .wr_asid(upd_asid), .wr_tgt(upd_target),
    .rd_idx(lk_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_asid(ent_asid), .rd_tgt(ent_tgt));

  btb_match #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_asid(ent_asid),
    .q_tag(lk_tag), .q_asid(lk_asid), .result(lk_res));

  assign lk_hit    = (lk_res == btb_pkg::LK_HIT);
  assign lk_target = lk_hit ? ent_tgt : '0;
  // No known target: a taken guess degrades to not taken
  assign lk_taken  = lk_pred_taken && lk_hit;

  // Table starts empty after reset
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_hit && lk_target == '0));

  // Taken write is seen by an identical lookup on the next cycle
  assert_alloc_visible_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en && upd_taken && !rst) && lk_pc == $past(upd_pc) && lk_asid == $past(upd_asid))
    |-> (lk_hit && lk_target == $past(upd_target)));

  // Without a taken write, a steady lookup gives a steady answer
  assert_no_alloc_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_en && upd_taken) && $stable(lk_pc) && $stable(lk_asid))
    |-> ($stable(lk_hit) && $stable(lk_target)));

  // Different address space at the freshly written entry misses
  assert_space_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en && upd_taken && !rst) && lk_idx == $past(up_idx) && lk_asid != $past(upd_asid))
    |-> !lk_hit);

  // Different tag at the freshly written index misses
  assert_tag_replaced_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en && upd_taken && !rst) && lk_idx == $past(up_idx) && lk_tag != $past(up_tag))
    |-> !lk_hit);
endmodule

// File: tb/asid_btb_bench.sv
`timescale 1ns/1ps
module asid_btb_bench;
  localparam int N   = 64;
  localparam int IW  = 6;
  localparam int TW  = 16;
  localparam int AW  = 8;
  localparam int PW  = 32;
  localparam int SH  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic [AW-1:0] lk_asid = '0, upd_asid = '0;
  logic lk_pred_taken = 1'b0, upd_en = 1'b0, upd_taken = 1'b0;
  logic lk_hit, lk_taken;
  logic [PW-1:0] lk_target;

  int checks = 0;
  int errors = 0;

  // Reference table
  logic          m_val [N];
  logic [TW-1:0] m_tag [N];
  logic [AW-1:0] m_as  [N];
  logic [PW-1:0] m_tgt [N];

  always #10 clk = ~clk;

  asid_btb #(.ENTRIES(N), .TAG_W(TW), .ASID_W(AW), .PC_W(PW), .PC_SHIFT(SH)) u_asid_btb (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_asid(lk_asid), .lk_pred_taken(lk_pred_taken),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_taken(lk_taken),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_asid(upd_asid), .upd_taken(upd_taken),
    .upd_target(upd_target));

  function automatic logic [PW-1:0] mk_pc(int idx, logic [TW-1:0] tag, logic [1:0] lo, logic [7:0] hi);
    return {hi, tag, idx[IW-1:0], lo};
  endfunction

  function automatic logic exp_hit(logic [PW-1:0] pc, logic [AW-1:0] as);
    int i;
    i = int'(pc[SH +: IW]);
    return m_val[i] && m_tag[i] == pc[SH+IW +: TW] && m_as[i] == as;
  endfunction

  function automatic logic [PW-1:0] exp_tgt(logic [PW-1:0] pc, logic [AW-1:0] as);
    return exp_hit(pc, as) ? m_tgt[int'(pc[SH +: IW])] : '0;
  endfunction

  task automatic chk(logic [PW-1:0] act, logic [PW-1:0] exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_lookup(string req);
    logic eh;
    eh = exp_hit(lk_pc, lk_asid);
    chk(PW'(lk_hit), PW'(eh), req, "hit");
    chk(lk_target, exp_tgt(lk_pc, lk_asid), req, "target");
    chk(PW'(lk_taken), PW'(eh && lk_pred_taken), req, "final direction (R8)");
  endtask

  // One cycle: drive after negedge, check before posedge, then mirror the write
  task automatic cycle(logic [PW-1:0] lpc, logic [AW-1:0] las, logic lpred,
                       logic ue, logic [PW-1:0] upc, logic [AW-1:0] uas, logic ut,
                       logic [PW-1:0] utg, string req);
    @(negedge clk);
    lk_pc = lpc; lk_asid = las; lk_pred_taken = lpred;
    upd_en = ue; upd_pc = upc; upd_asid = uas; upd_taken = ut; upd_target = utg;
    #2;
    check_lookup(req);
    if (ue && ut && !rst) begin
      m_val[int'(upc[SH +: IW])] = 1'b1;
      m_tag[int'(upc[SH +: IW])] = upc[SH+IW +: TW];
      m_as[int'(upc[SH +: IW])]  = uas;
      m_tgt[int'(upc[SH +: IW])] = utg;
    end
  endtask

  task automatic look(logic [PW-1:0] lpc, logic [AW-1:0] las, logic lpred, string req);
    cycle(lpc, las, lpred, 1'b0, '0, '0, 1'b0, '0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] a, b, c;
    logic [TW-1:0] tp [3];
    tp[0] = 16'h1234; tp[1] = 16'hBEEF; tp[2] = 16'h0007;
    for (int i = 0; i < N; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_as[i] = '0; m_tgt[i] = '0;
    end
    void'($urandom(32'd4242));
    do_reset();

    // R1: empty after reset
    look(mk_pc(5, 16'h1234, 2'd0, 8'h00), 8'd3, 1'b1, "R1");
    look(mk_pc(63, 16'hFFFF, 2'd3, 8'hFF), 8'd0, 1'b1, "R1");

    a = mk_pc(9, 16'h1234, 2'd0, 8'h00);
    // R3: allocate on taken, visible next cycle
    cycle(a, 8'd3, 1'b1, 1'b1, a, 8'd3, 1'b1, 32'hCAFE_0010, "R3");
    look(a, 8'd3, 1'b1, "R3");
    look(a, 8'd3, 1'b0, "R8");
    // R5: other address space misses
    look(a, 8'd4, 1'b1, "R5");
    // R2/R6: same index, other tag misses
    look(mk_pc(9, 16'h1235, 2'd0, 8'h00), 8'd3, 1'b1, "R2");
    // R9: ignored low and high bits
    look(mk_pc(9, 16'h1234, 2'd3, 8'hA5), 8'd3, 1'b1, "R9");
    // R4: not-taken update changes nothing
    cycle(a, 8'd3, 1'b1, 1'b1, a, 8'd7, 1'b0, 32'h0BAD_0000, "R4");
    look(a, 8'd3, 1'b1, "R4");
    b = mk_pc(20, 16'hBEEF, 2'd0, 8'h00);
    cycle(b, 8'd1, 1'b1, 1'b1, b, 8'd1, 1'b0, 32'h0BAD_0001, "R4");
    look(b, 8'd1, 1'b1, "R4");
    chk(PW'(lk_hit), '0, "R4", "not-taken did not allocate");
    // R7: same-cycle read of written index returns old data
    cycle(a, 8'd3, 1'b1, 1'b1, a, 8'd3, 1'b1, 32'hCAFE_0020, "R7");
    chk(lk_target, 32'hCAFE_0010, "R7", "old target during write");
    look(a, 8'd3, 1'b1, "R7");
    // R6: overwrite same index with another tag
    c = mk_pc(9, 16'hBEEF, 2'd1, 8'h00);
    cycle(a, 8'd3, 1'b1, 1'b1, c, 8'd2, 1'b1, 32'hCAFE_0030, "R6");
    look(a, 8'd3, 1'b1, "R6");
    look(c, 8'd2, 1'b1, "R6");
    // R8: miss with taken guess yields not taken
    look(b, 8'd1, 1'b1, "R8");
    chk(PW'(lk_taken), '0, "R8", "miss forces not taken");
    // R10: outputs follow inputs within one cycle
    look(c, 8'd2, 1'b1, "R10");
    lk_pc = b; #2;
    check_lookup("R10");
    lk_pc = c; #2;
    check_lookup("R10");
    // R1: reset clears populated table
    do_reset();
    look(c, 8'd2, 1'b1, "R1");

    // Random mix over a small PC pool (R2, R3, R4, R7)
    for (int n = 0; n < 3000; n++) begin
      logic [PW-1:0] lp, up;
      lp = mk_pc(int'($urandom_range(0, 7)), tp[$urandom_range(0, 2)],
                 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
      up = mk_pc(int'($urandom_range(0, 7)), tp[$urandom_range(0, 2)],
                 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
      cycle(lp, 8'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), up, 8'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), $urandom(), "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule